// File: doc/BRIEF.md
# Banked Translation-Entry Register File

This block is the special-register side of a small memory-management unit. Software reaches it through a write port and a read port. Each port carries a register number, and the write port also carries data. Which of four 16-register banks both ports address depends on a separate bank-select register. Two of the banks, numbered 1 and 2, are MMU banks. Each MMU bank owns an array of translation entries arranged as 4 sets of 16 entries, and each entry holds a 32-bit high word and a 32-bit low word.

In an MMU bank, four registers have special meaning. Register 3 selects an entry. Register 4 is the cause register, which stages the high word of the next entry. Registers 5 and 6 mirror the low and high words of the selected entry. Writing the low mirror commits a whole entry. Reading any register in an MMU bank first reloads both mirrors from the selected entry.

When a commit replaces an entry that was valid, the block pulses an invalidate output that carries the page address of the replaced translation. A separate PID port tracks the current address-space identifier. It raises a flush request only when the identifier actually changes.

Top module: `mmu_tlb_regs`

## Requirements
- R1: After a synchronous reset, all bank registers, all translation entries, the bank select and the current PID are zero. `rd_data`, `inval_o`, `inval_addr`, `flush_o` and `flush_pid` are also zero.
- R2: In every bank, a write of `wr_data` to register `wr_reg` is returned by a later read of that register in the same bank. A write in one bank leaves the other banks unchanged. In banks 0 and 3, registers 3 to 6 behave as plain storage.
- R3: In an MMU bank (bank 1 or 2), a write to register 6 also stores the same data in register 4 (the cause register).
- R4: In an MMU bank, a write to register 5 commits an entry in that bank's array. The low word of the entry is `wr_data` and the high word is the current content of register 4. The entry is addressed by register 3 of that bank: bits 5:4 give the set and bits 3:0 give the index.
- R5: A read of any register in an MMU bank returns the requested value and also reloads registers 6 and 5 with the high and low words of the selected entry. A read of register 6 or 5 therefore returns the entry words, not what was last written there.
- R6: Banks 1 and 2 each address their own entry array. A commit through one bank cannot be seen through the other.
- R7: When a commit replaces an entry whose old low word has bit 3 set, `inval_o` pulses. `inval_addr` then equals the old high word with bits 12:0 cleared. A commit over an entry whose bit 3 is clear gives no pulse.
- R8: `inval_o` is high in exactly the one cycle after the committing write, and `inval_addr` holds its value until the next pulse.
- R9: Only bits 1:0 of `bsel_data` choose the bank. The upper bits have no effect.
- R10: A PID write pulses `flush_o` for one cycle only if bits 7:0 of `pid_data` differ from bits 7:0 of the current PID. On that pulse, `flush_pid` reports the previous low byte. The new PID replaces the current one whether or not a flush is raised.
- R11: `rd_data` is registered. It changes only in the cycle after `rd_en` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bsel_we | input | 1 | Bank-select write strobe |
| bsel_data | input | 32 | New bank-select value; bits 1:0 used |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 4 | Register number written |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_reg | input | 4 | Register number read |
| rd_data | output | 32 | Registered read data |
| pid_we | input | 1 | PID write strobe |
| pid_data | input | 32 | New PID; bits 7:0 compared |
| inval_o | output | 1 | One-cycle page invalidate pulse |
| inval_addr | output | 32 | Page address of the replaced valid entry |
| flush_o | output | 1 | One-cycle PID flush request |
| flush_pid | output | 8 | Previous PID low byte for the flush |

## Verification
The cause-register property expects a write to register 6 not to coincide with a bank-select write, because the property observes the bank that is active after the edge. The invalidate and flush properties assume that reset is held from time zero. The stimulus tasks issue exactly one operation per cycle and never combine a read with a write or with a bank-select change, which keeps every property's antecedent within these limits. Entry selectors span the corner values 0x00 and 0x3F and both MMU banks.

// File: rtl/tlbra_pkg.sv
package tlbra_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_BANKS = 16 / 4;
  localparam int NUM_REGS  = 16;
  localparam int FIRST_MMU = 1;
  localparam int NUM_MMU   = 2;
  localparam int NUM_SETS  = 4;
  localparam int NUM_ENT   = 16;
  localparam int PAGE_BITS = 13;
  localparam int VALID_BIT = 3;
  localparam int PID_W     = 8;
  // bank-local register numbers with special meaning in MMU banks
  localparam int SR_SEL    = 3;
  localparam int SR_CAUSE  = 4;
  localparam int SR_LO     = 5;
  localparam int SR_HI     = 6;
endpackage

// File: rtl/tlbra_bank_file.sv
module tlbra_bank_file #(
  parameter int DATA_W    = tlbra_pkg::DATA_W,
  parameter int NUM_BANKS = tlbra_pkg::NUM_BANKS,
  parameter int NUM_REGS  = tlbra_pkg::NUM_REGS,
  parameter int FIRST_MMU = tlbra_pkg::FIRST_MMU,
  parameter int NUM_MMU   = tlbra_pkg::NUM_MMU,
  parameter int SEL_REG   = tlbra_pkg::SR_SEL,
  parameter int CAUSE_REG = tlbra_pkg::SR_CAUSE,
  parameter int LO_REG    = tlbra_pkg::SR_LO,
  parameter int HI_REG    = tlbra_pkg::SR_HI,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bsel_we,
  input  logic [DATA_W-1:0] bsel_data,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic [DATA_W-1:0] ent_hi,
  input  logic [DATA_W-1:0] ent_lo,
  output logic [DATA_W-1:0] rd_data,
  output logic [BANK_W-1:0] bank_o,
  output logic              mmu_o,
  output logic [DATA_W-1:0] sel_o,
  output logic [DATA_W-1:0] cause_o
);
  localparam logic [REG_W-1:0]  R_SEL   = REG_W'(SEL_REG);
  localparam logic [REG_W-1:0]  R_CAUSE = REG_W'(CAUSE_REG);
  localparam logic [REG_W-1:0]  R_LO    = REG_W'(LO_REG);
  localparam logic [REG_W-1:0]  R_HI    = REG_W'(HI_REG);
  localparam logic [BANK_W-1:0] MMU_LO  = BANK_W'(FIRST_MMU);
  localparam logic [BANK_W-1:0] MMU_HI  = BANK_W'(FIRST_MMU + NUM_MMU - 1);

  logic [DATA_W-1:0] regs_q [NUM_BANKS][NUM_REGS];
  logic [BANK_W-1:0] bsel_q;
  logic [DATA_W-1:0] rd_next;
  logic              unused_bsel;

  assign unused_bsel = ^bsel_data[DATA_W-1:BANK_W];
  assign bank_o  = bsel_q;
  assign mmu_o   = (bsel_q >= MMU_LO) && (bsel_q <= MMU_HI);
  assign sel_o   = regs_q[bsel_q][R_SEL];
  assign cause_o = regs_q[bsel_q][R_CAUSE];

  // In an MMU bank the mirror registers read as the selected entry.
  always_comb begin
    rd_next = regs_q[bsel_q][rd_reg];
    if (mmu_o && rd_reg == R_HI) rd_next = ent_hi;
    if (mmu_o && rd_reg == R_LO) rd_next = ent_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsel_q  <= '0;
      rd_data <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < NUM_REGS; r++)
          regs_q[b][r] <= '0;
    end else begin
      if (bsel_we) bsel_q <= bsel_data[BANK_W-1:0];
      if (rd_en) begin
        rd_data <= rd_next;
        if (mmu_o) begin
          regs_q[bsel_q][R_HI] <= ent_hi;
          regs_q[bsel_q][R_LO] <= ent_lo;
        end
      end
      // a write in the same cycle lands after the refresh and wins
      if (wr_en) begin
        regs_q[bsel_q][wr_reg] <= wr_data;
        if (mmu_o && wr_reg == R_HI) regs_q[bsel_q][R_CAUSE] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tlbra_entry_store.sv
module tlbra_entry_store #(
  parameter int DATA_W    = tlbra_pkg::DATA_W,
  parameter int NUM_MMU   = tlbra_pkg::NUM_MMU,
  parameter int NUM_SETS  = tlbra_pkg::NUM_SETS,
  parameter int NUM_ENT   = tlbra_pkg::NUM_ENT,
  parameter int PAGE_BITS = tlbra_pkg::PAGE_BITS,
  parameter int VALID_BIT = tlbra_pkg::VALID_BIT,
  localparam int K_W      = (NUM_MMU > 1) ? $clog2(NUM_MMU) : 1,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int IDX_W    = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [K_W-1:0]    kbank,
  input  logic [SET_W-1:0]  set_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] new_lo,
  input  logic [DATA_W-1:0] new_hi,
  output logic [DATA_W-1:0] ent_lo,
  output logic [DATA_W-1:0] ent_hi,
  output logic              inval_o,
  output logic [DATA_W-1:0] inval_addr_o
);
  logic [DATA_W-1:0] lo_q [NUM_MMU][NUM_SETS][NUM_ENT];
  logic [DATA_W-1:0] hi_q [NUM_MMU][NUM_SETS][NUM_ENT];

  assign ent_lo = lo_q[kbank][set_i][idx_i];
  assign ent_hi = hi_q[kbank][set_i][idx_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      inval_o      <= 1'b0;
      inval_addr_o <= '0;
      for (int k = 0; k < NUM_MMU; k++)
        for (int s = 0; s < NUM_SETS; s++)
          for (int e = 0; e < NUM_ENT; e++) begin
            lo_q[k][s][e] <= '0;
            hi_q[k][s][e] <= '0;
          end
    end else begin
      inval_o <= 1'b0;
      if (commit) begin
        lo_q[kbank][set_i][idx_i] <= new_lo;
        hi_q[kbank][set_i][idx_i] <= new_hi;
        if (ent_lo[VALID_BIT]) begin
          inval_o      <= 1'b1;
          inval_addr_o <= {ent_hi[DATA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        end
      end
    end
  end
endmodule

// File: rtl/tlbra_pid_track.sv
module tlbra_pid_track #(
  parameter int DATA_W = tlbra_pkg::DATA_W,
  parameter int PID_W  = tlbra_pkg::PID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pid_we,
  input  logic [DATA_W-1:0] pid_data,
  output logic              flush_o,
  output logic [PID_W-1:0]  flush_pid_o
);
  logic [PID_W-1:0] pid_q;
  logic             unused_pid;

  assign unused_pid = ^pid_data[DATA_W-1:PID_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q       <= '0;
      flush_o     <= 1'b0;
      flush_pid_o <= '0;
    end else begin
      flush_o <= 1'b0;
      if (pid_we) begin
        pid_q <= pid_data[PID_W-1:0];
        if (pid_data[PID_W-1:0] != pid_q) begin
          flush_o     <= 1'b1;
          flush_pid_o <= pid_q;
        end
      end
    end
  end
endmodule

// File: rtl/mmu_tlb_regs.sv
module mmu_tlb_regs #(
  parameter int DATA_W    = tlbra_pkg::DATA_W,
  parameter int NUM_BANKS = tlbra_pkg::NUM_BANKS,
  parameter int NUM_REGS  = tlbra_pkg::NUM_REGS,
  parameter int FIRST_MMU = tlbra_pkg::FIRST_MMU,
  parameter int NUM_MMU   = tlbra_pkg::NUM_MMU,
  parameter int NUM_SETS  = tlbra_pkg::NUM_SETS,
  parameter int NUM_ENT   = tlbra_pkg::NUM_ENT,
  parameter int PAGE_BITS = tlbra_pkg::PAGE_BITS,
  parameter int PID_W     = tlbra_pkg::PID_W,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bsel_we,
  input  logic [DATA_W-1:0] bsel_data,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  rd_reg,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pid_we,
  input  logic [DATA_W-1:0] pid_data,
  output logic              inval_o,
  output logic [DATA_W-1:0] inval_addr,
  output logic              flush_o,
  output logic [PID_W-1:0]  flush_pid
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int K_W    = (NUM_MMU > 1) ? $clog2(NUM_MMU) : 1;
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int IDX_W  = $clog2(NUM_ENT);
  localparam logic [REG_W-1:0] R_LO = REG_W'(tlbra_pkg::SR_LO);

  logic [BANK_W-1:0] bank, kfull;
  logic              mmu_act, commit;
  logic [DATA_W-1:0] sel_val, cause_val, ent_hi, ent_lo;
  logic              unused_sel;

  assign kfull      = bank - BANK_W'(FIRST_MMU);
  assign commit     = wr_en && mmu_act && (wr_reg == R_LO);
  assign unused_sel = ^{sel_val[DATA_W-1:SET_W+IDX_W], kfull};

  tlbra_bank_file #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS),
    .FIRST_MMU(FIRST_MMU), .NUM_MMU(NUM_MMU)
  ) u_banks (
    .clk(clk), .rst(rst), .bsel_we(bsel_we), .bsel_data(bsel_data),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_en(rd_en), .rd_reg(rd_reg), .ent_hi(ent_hi), .ent_lo(ent_lo),
    .rd_data(rd_data), .bank_o(bank), .mmu_o(mmu_act),
    .sel_o(sel_val), .cause_o(cause_val)
  );

  tlbra_entry_store #(
    .DATA_W(DATA_W), .NUM_MMU(NUM_MMU), .NUM_SETS(NUM_SETS),
    .NUM_ENT(NUM_ENT), .PAGE_BITS(PAGE_BITS)
  ) u_entries (
    .clk(clk), .rst(rst), .commit(commit), .kbank(kfull[K_W-1:0]),
    .set_i(sel_val[IDX_W +: SET_W]), .idx_i(sel_val[IDX_W-1:0]),
    .new_lo(wr_data), .new_hi(cause_val),
    .ent_lo(ent_lo), .ent_hi(ent_hi),
    .inval_o(inval_o), .inval_addr_o(inval_addr)
  );

  tlbra_pid_track #(.DATA_W(DATA_W), .PID_W(PID_W)) u_pid (
    .clk(clk), .rst(rst), .pid_we(pid_we), .pid_data(pid_data),
    .flush_o(flush_o), .flush_pid_o(flush_pid)
  );
endmodule

// File: rtl/mmu_tlb_regs_chk.sv
module mmu_tlb_regs_chk #(
  parameter int DATA_W    = 32,
  parameter int REG_W     = 4,
  parameter int PID_W     = 8,
  parameter int PAGE_BITS = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              bsel_we,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_reg,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              pid_we,
  input logic [DATA_W-1:0] pid_data,
  input logic              inval_o,
  input logic [DATA_W-1:0] inval_addr,
  input logic              flush_o,
  input logic [PID_W-1:0]  flush_pid,
  input logic              mmu_act,
  input logic [DATA_W-1:0] cause_val
);
  localparam logic [REG_W-1:0] R_LO = REG_W'(tlbra_pkg::SR_LO);
  localparam logic [REG_W-1:0] R_HI = REG_W'(tlbra_pkg::SR_HI);

  AST_HI_SETS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mmu_act && wr_reg == R_HI && !bsel_we) |=> (cause_val == $past(wr_data))); // R3
  AST_INVAL_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
    inval_o |-> $past(wr_en && mmu_act && wr_reg == R_LO)); // R7
  AST_INVAL_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    inval_o |-> (inval_addr[PAGE_BITS-1:0] == '0)); // R7
  AST_INVAL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !inval_o |=> (inval_o || $stable(inval_addr))); // R8
  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> ($past(pid_we) && flush_pid != $past(pid_data[PID_W-1:0]))); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R11
endmodule

bind mmu_tlb_regs mmu_tlb_regs_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .PID_W(PID_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst(rst), .bsel_we(bsel_we), .wr_en(wr_en), .wr_reg(wr_reg),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pid_we(pid_we),
  .pid_data(pid_data), .inval_o(inval_o), .inval_addr(inval_addr),
  .flush_o(flush_o), .flush_pid(flush_pid), .mmu_act(mmu_act),
  .cause_val(cause_val)
);

// File: tb/mmu_tlb_regs_tb.sv
`timescale 1ns/1ps
module mmu_tlb_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bsel_we = 1'b0, wr_en = 1'b0, rd_en = 1'b0, pid_we = 1'b0;
  logic [31:0] bsel_data = '0, wr_data = '0, pid_data = '0;
  logic [3:0]  wr_reg = '0, rd_reg = '0;
  logic [31:0] rd_data, inval_addr;
  logic        inval_o, flush_o;
  logic [7:0]  flush_pid;

  int    checks = 0, failures = 0;
  bit    started = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mmu_tlb_regs u_dut (
    .clk(clk), .rst(rst), .bsel_we(bsel_we), .bsel_data(bsel_data),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_en(rd_en), .rd_reg(rd_reg), .rd_data(rd_data),
    .pid_we(pid_we), .pid_data(pid_data),
    .inval_o(inval_o), .inval_addr(inval_addr),
    .flush_o(flush_o), .flush_pid(flush_pid)
  );

  // behavioural reference model
  logic [31:0] m_regs [4][16];
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic [1:0]  m_bank;
  logic [7:0]  m_pid;
  logic [31:0] e_rd, e_ia;
  logic        e_inv, e_fl;
  logic [7:0]  e_fp;

  always @(posedge clk) begin
    int b, k, s, i;
    bit mmu;
    started = 1'b1;
    if (rst) begin
      foreach (m_regs[x, y]) m_regs[x][y] = '0;
      foreach (m_hi[x, y, z]) begin m_hi[x][y][z] = '0; m_lo[x][y][z] = '0; end
      m_bank = '0; m_pid = '0;
      e_rd = '0; e_ia = '0; e_inv = 1'b0; e_fl = 1'b0; e_fp = '0;
    end else begin
      b   = int'(m_bank);
      mmu = (b == 1) || (b == 2);
      k   = mmu ? b - 1 : 0;
      s   = int'(m_regs[b][3][5:4]);
      i   = int'(m_regs[b][3][3:0]);
      e_inv = 1'b0;
      e_fl  = 1'b0;
      if (rd_en) begin
        if (mmu && rd_reg == 4'd6)      e_rd = m_hi[k][s][i];
        else if (mmu && rd_reg == 4'd5) e_rd = m_lo[k][s][i];
        else                            e_rd = m_regs[b][rd_reg];
        if (mmu) begin
          m_regs[b][6] = m_hi[k][s][i];
          m_regs[b][5] = m_lo[k][s][i];
        end
      end
      if (wr_en) begin
        if (mmu && wr_reg == 4'd5) begin
          if (m_lo[k][s][i][3]) begin
            e_inv = 1'b1;
            e_ia  = m_hi[k][s][i] & 32'hFFFF_E000;
          end
          m_hi[k][s][i] = m_regs[b][4];
          m_lo[k][s][i] = wr_data;
        end
        m_regs[b][wr_reg] = wr_data;
        if (mmu && wr_reg == 4'd6) m_regs[b][4] = wr_data;
      end
      if (bsel_we) m_bank = bsel_data[1:0];
      if (pid_we) begin
        if (pid_data[7:0] != m_pid) begin e_fl = 1'b1; e_fp = m_pid; end
        m_pid = pid_data[7:0];
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("rd_data", rd_data, e_rd);
      chk("inval_o", {31'b0, inval_o}, {31'b0, e_inv});
      chk("inval_addr", inval_addr, e_ia);
      chk("flush_o", {31'b0, flush_o}, {31'b0, e_fl});
      chk("flush_pid", {24'b0, flush_pid}, {24'b0, e_fp});
    end
  end

  task automatic wr(input logic [3:0] r, input logic [31:0] d);
    wr_en = 1'b1; wr_reg = r; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [3:0] r);
    rd_en = 1'b1; rd_reg = r;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic bank(input logic [31:0] d);
    bsel_we = 1'b1; bsel_data = d;
    @(negedge clk); bsel_we = 1'b0;
  endtask
  task automatic pid(input logic [31:0] d);
    pid_we = 1'b1; pid_data = d;
    @(negedge clk); pid_we = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    idle(2);
    for (int r = 0; r < 16; r++) rd(4'(r));
    cur_req = "R11"; idle(3);

    cur_req = "R2";
    wr(4'd5, 32'hA5A5_0005); wr(4'd6, 32'h0606_0606); wr(4'd3, 32'h0000_003F);
    rd(4'd5); rd(4'd6); rd(4'd4); rd(4'd3);
    cur_req = "R9";
    bank(32'hFFFF_FFF3);
    cur_req = "R2";
    rd(4'd5); wr(4'd6, 32'h3333_6666); rd(4'd6); rd(4'd4);
    bank(32'h0000_0000); rd(4'd6);

    cur_req = "R9";
    bank(32'hABCD_0001);
    rd(4'd3);
    cur_req = "R3";
    wr(4'd3, 32'h0000_0025);
    wr(4'd6, 32'h1234_A000); rd(4'd4);
    cur_req = "R4";
    wr(4'd5, 32'h0000_0008); idle(1); rd(4'd5); rd(4'd6);
    cur_req = "R5";
    wr(4'd6, 32'h5555_0000); rd(4'd6); rd(4'd4); rd(4'd5);
    cur_req = "R7";
    wr(4'd6, 32'hFEDC_FFFF); wr(4'd5, 32'h0000_0008);
    cur_req = "R8"; idle(2);
    cur_req = "R7";
    wr(4'd5, 32'h0000_0000); idle(1);
    wr(4'd5, 32'h0000_0005); idle(1);
    wr(4'd5, 32'h0000_000C); wr(4'd5, 32'h0000_0008);
    cur_req = "R8"; idle(2);

    cur_req = "R6";
    bank(32'h0000_0002);
    wr(4'd3, 32'h0000_0025); rd(4'd6); rd(4'd5);
    wr(4'd6, 32'h2222_2000); wr(4'd5, 32'h0000_0009); rd(4'd6);
    bank(32'h0000_0001); rd(4'd6); rd(4'd5);
    bank(32'h0000_0002); rd(4'd6);

    cur_req = "R4";
    for (int n = 0; n < 8; n++) begin
      logic [5:0] sv = (n == 0) ? 6'h00 : (n == 1) ? 6'h3F : 6'(n * 9);
      wr(4'd3, {26'b0, sv});
      wr(4'd6, 32'h0100_0000 * (n + 1) + 32'h0000_2000);
      wr(4'd5, 32'h0000_0008 | (32'(n) << 8));
    end
    for (int n = 0; n < 8; n++) begin
      logic [5:0] sv = (n == 0) ? 6'h00 : (n == 1) ? 6'h3F : 6'(n * 9);
      wr(4'd3, {26'b0, sv});
      rd(4'd6); rd(4'd5);
      cur_req = "R7";
      wr(4'd5, 32'h0000_0000); idle(1);
      cur_req = "R4";
    end

    cur_req = "R10";
    pid(32'h0000_0100); idle(1);
    pid(32'h0000_01AB); idle(1);
    pid(32'h0000_02AB); idle(1);
    pid(32'h0000_0000); pid(32'h0000_0011); idle(2);

    cur_req = "R11"; idle(3);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule